// File: doc/BRIEF.md
# Rounding and Quadrant-Fold Quantizer

This block shrinks a pair of signed in-phase (I) and quadrature (Q) samples into short codes that a downstream table can use as an address. Each rail keeps only its most significant bits. The number of bits kept depends on the mode. The discarded bits are either dropped outright or used to round the kept part to the nearest code. Exact halfway cases round to the even code.

The block has two output modes. In the plain mode, each rail gives a short two's-complement code. In the fold mode, each rail keeps one extra bit of precision. That wider signed value is then turned into an unsigned magnitude and a separate sign flag, so that a table built for a single quadrant can serve all four. Negative values can be negated exactly, or with a cheaper bit inversion that is off by one. Both rails are computed in parallel with the same controls, and the results are registered once.

Top module: `qf_quantizer`

## Requirements
- R1: With the fold control high, each rail's sample is reduced to its upper CODE_W+1 bits. With the fold control low, it is reduced to its upper CODE_W bits. With defaults and truncation, input 32 yields code 1 when folded and code 0 when not folded.
- R2: With the fold control low, the code output carries the reduced value as CODE_W-bit two's complement, and the sign output is 0. With defaults, input -2048 gives code 32 (binary 100000).
- R3: With the round control high, the reduced value is the nearest integer to the sample divided by 2^dropped. An exact half rounds to the even code.
- R4: With the round control low, the reduced value is the floor of the sample divided by 2^dropped, which is plain truncation.
- R5: A round-up that would pass the largest positive reduced value leaves that largest value in place instead of wrapping. With defaults, input 2047 rounds to 31 unfolded and to magnitude 63 folded.
- R6: In fold mode, a non-negative reduced value is output unchanged as the magnitude, with the sign output 0.
- R7: In fold mode with the invert control low, a negative reduced value gives sign 1 and its exact two's-complement negation as the magnitude. The most negative value (-64 by default) saturates to magnitude 63.
- R8: In fold mode with the invert control high, a negative reduced value gives sign 1 and the bitwise inverse of its low CODE_W bits as the magnitude, which is -value-1.
- R9: Both rails use the same rule independently. Each output changes only at the clock edge after its inputs, which is one cycle of latency.
- R10: While reset is low, all code and sign outputs are 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| round_en | input | 1 | 1: round half to even, 0: truncate |
| fold_en | input | 1 | 1: fold to magnitude plus sign, 0: plain signed code |
| neg_inv | input | 1 | 1: negate by bit inversion when folding, 0: exact negation |
| i_in | input | IN_W (12) | I sample, two's complement |
| q_in | input | IN_W (12) | Q sample, two's complement |
| i_code | output | CODE_W (6) | I code: signed value or magnitude |
| i_sign | output | 1 | I sign flag in fold mode, else 0 |
| q_code | output | CODE_W (6) | Q code: signed value or magnitude |
| q_sign | output | 1 | Q sign flag in fold mode, else 0 |

## Verification
The bench builds the block with its defaults: 12-bit samples and 6-bit codes. At that size, every input value on a rail can be swept under all eight combinations of the round, fold and invert controls in about 33k cycles. The Q rail is fed an odd-multiplier permutation of the I sweep, so both rails cover every value while seeing different samples. Every rounding tie, the positive saturation point and the most negative folded value are therefore reached, along with directed checks of latency and reset.

// File: rtl/qf_pkg.sv
package qf_pkg;

   // How a negative value is turned into a magnitude
   typedef enum logic {
      NEG_EXACT  = 1'b0,
      NEG_INVERT = 1'b1
   } neg_sel_e;

   // Rail indices inside the top level
   typedef enum int {
      RAIL_I = 0,
      RAIL_Q = 1
   } rail_e;

   localparam int NUM_RAILS = 2;

endpackage

// File: rtl/qf_round.sv
module qf_round #(
   parameter int IN_W  = 12,
   parameter int OUT_W = 6
) (
   input  logic [IN_W-1:0]  din,
   input  logic             round_en,
   output logic [OUT_W-1:0] dout
);
   localparam int DROP = IN_W - OUT_W;
   localparam logic [DROP-1:0]  HALF = {1'b1, {(DROP-1){1'b0}}};
   localparam logic [OUT_W-1:0] MAXP = {1'b0, {(OUT_W-1){1'b1}}};

   if (DROP < 2) begin : g_bad_drop
      $error("qf_round: at least two bits must be dropped");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("qf_round: output narrower than two bits");
   end

   logic [OUT_W-1:0] kept;
   logic [DROP-1:0]  frac;
   logic             bump;
   logic             at_max;

   assign kept   = din[IN_W-1:DROP];
   assign frac   = din[DROP-1:0];
   assign at_max = (kept == MAXP);
   assign bump   = round_en & ((frac > HALF) | ((frac == HALF) & kept[0]));
   assign dout   = (bump && !at_max) ? kept + OUT_W'(1) : kept;

   // Numeric check of the error against the rule for each mode
   logic signed [31:0] v_in, v_out, diff;
   localparam logic signed [31:0] HALF_I = 32'sd1 <<< (DROP-1);
   localparam logic signed [31:0] SPAN_I = 32'sd1 <<< DROP;

   assign v_in  = {{(32-IN_W){din[IN_W-1]}}, din};
   assign v_out = {{(32-OUT_W){dout[OUT_W-1]}}, dout};
   assign diff  = v_in - (v_out <<< DROP);

   always_comb begin
      if (!$isunknown({din, round_en})) begin
         if (round_en) begin
            a_r3_nearest: assert ((diff <= HALF_I && diff >= -HALF_I) || dout == MAXP)
               else $error("round result not nearest");
            a_r5_no_wrap: assert (!(v_in >= 0 && v_out < 0))
               else $error("positive rounding wrapped");
         end else begin
            a_r4_floor: assert (diff >= 0 && diff < SPAN_I)
               else $error("truncation not floor");
         end
      end
   end

endmodule

// File: rtl/qf_fold.sv
module qf_fold
   import qf_pkg::*;
#(
   parameter int W = 7
) (
   input  logic [W-1:0] v,
   input  logic         inv,
   output logic [W-2:0] mag,
   output logic         sign
);
   localparam logic [W-2:0] MAG_MAX = '1;

   if (W < 3) begin : g_bad_w
      $error("qf_fold: width too small");
   end

   neg_sel_e     sel;
   logic [W-1:0] exact_neg;
   logic [W-2:0] inv_neg;

   assign sel       = neg_sel_e'(inv);
   assign exact_neg = ~v + W'(1);
   assign inv_neg   = ~v[W-2:0];
   assign sign      = v[W-1];

   always_comb begin
      if (!v[W-1]) begin
         mag = v[W-2:0];
      end else begin
         unique case (sel)
            NEG_INVERT: mag = inv_neg;
            default:    mag = exact_neg[W-1] ? MAG_MAX : exact_neg[W-2:0];
         endcase
      end
   end

   logic signed [31:0] vv, mm;
   assign vv = {{(32-W){v[W-1]}}, v};
   assign mm = {{(33-W){1'b0}}, mag};

   always_comb begin
      if (!$isunknown({v, inv})) begin
         if (!sign) begin
            a_r6_pos_same: assert (mm == vv) else $error("positive magnitude altered");
         end else if (!inv) begin
            a_r7_exact: assert (mm + vv == 0 || (mag == MAG_MAX && mm + vv == -1 && vv == -(mm + 1)))
               else $error("exact negation wrong");
         end else begin
            a_r8_invert: assert (mm + vv == -1) else $error("inverted negation wrong");
         end
      end
   end

endmodule

// File: rtl/qf_rail.sv
module qf_rail #(
   parameter int IN_W   = 12,
   parameter int CODE_W = 6
) (
   input  logic [IN_W-1:0]   din,
   input  logic              round_en,
   input  logic              fold_en,
   input  logic              neg_inv,
   output logic [CODE_W-1:0] code,
   output logic              sign
);
   logic [CODE_W-1:0] narrow;
   logic [CODE_W:0]   wide;
   logic [CODE_W-1:0] mag;
   logic              fsign;

   // One rounder per output width: plain width and fold width
   for (genvar g = 0; g < 2; g++) begin : g_rnd
      localparam int W = CODE_W + g;
      logic [W-1:0] r;
      qf_round #(.IN_W(IN_W), .OUT_W(W)) i_round (
         .din      (din),
         .round_en (round_en),
         .dout     (r)
      );
      if (g == 0) begin : g_narrow
         assign narrow = r;
      end else begin : g_wide
         assign wide = r;
      end
   end

   qf_fold #(.W(CODE_W+1)) i_fold (
      .v    (wide),
      .inv  (neg_inv),
      .mag  (mag),
      .sign (fsign)
   );

   assign code = fold_en ? mag : narrow;
   assign sign = fold_en & fsign;

endmodule

// File: rtl/qf_quantizer.sv
module qf_quantizer
   import qf_pkg::*;
#(
   parameter int IN_W   = 12,
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              round_en,
   input  logic              fold_en,
   input  logic              neg_inv,
   input  logic [IN_W-1:0]   i_in,
   input  logic [IN_W-1:0]   q_in,
   output logic [CODE_W-1:0] i_code,
   output logic              i_sign,
   output logic [CODE_W-1:0] q_code,
   output logic              q_sign
);
   if (IN_W < CODE_W + 3) begin : g_bad_widths
      $error("qf_quantizer: IN_W must exceed CODE_W by at least 3");
   end

   logic [IN_W-1:0]   rail_in   [NUM_RAILS];
   logic [CODE_W-1:0] rail_code [NUM_RAILS];
   logic              rail_sign [NUM_RAILS];
   logic [CODE_W-1:0] reg_code  [NUM_RAILS];
   logic              reg_sign  [NUM_RAILS];

   assign rail_in[RAIL_I] = i_in;
   assign rail_in[RAIL_Q] = q_in;

   for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
      qf_rail #(.IN_W(IN_W), .CODE_W(CODE_W)) i_rail (
         .din      (rail_in[r]),
         .round_en (round_en),
         .fold_en  (fold_en),
         .neg_inv  (neg_inv),
         .code     (rail_code[r]),
         .sign     (rail_sign[r])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            reg_code[r] <= '0;
            reg_sign[r] <= 1'b0;
         end else begin
            reg_code[r] <= rail_code[r];
            reg_sign[r] <= rail_sign[r];
         end
      end
   end

   assign i_code = reg_code[RAIL_I];
   assign i_sign = reg_sign[RAIL_I];
   assign q_code = reg_code[RAIL_Q];
   assign q_sign = reg_sign[RAIL_Q];

   // Set one edge after reset release; gates the history-based checks
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   a_r2_no_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !fold_en) |=> (!i_sign && !q_sign))
      else $error("sign raised without fold");

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $stable(i_in) && $stable(q_in) && $stable(round_en)
       && $stable(fold_en) && $stable(neg_inv))
      |=> ($stable(i_code) && $stable(q_code) && $stable(i_sign) && $stable(q_sign)))
      else $error("outputs moved with steady inputs");

endmodule

// File: tb/test_qf_quantizer.sv
module test_qf_quantizer;
   localparam int IN_W   = 12;
   localparam int CODE_W = 6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              round_en, fold_en, neg_inv;
   logic [IN_W-1:0]   i_in, q_in;
   logic [CODE_W-1:0] i_code, q_code;
   logic              i_sign, q_sign;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   qf_quantizer #(.IN_W(IN_W), .CODE_W(CODE_W)) i_qf_quantizer (
      .clk      (clk),
      .rst_n    (rst_n),
      .round_en (round_en),
      .fold_en  (fold_en),
      .neg_inv  (neg_inv),
      .i_in     (i_in),
      .q_in     (q_in),
      .i_code   (i_code),
      .i_sign   (i_sign),
      .q_code   (q_code),
      .q_sign   (q_sign)
   );

   // Expected {sign, code} from the arithmetic rules
   function automatic int model(input logic [IN_W-1:0] x, input bit rnd, input bit fld,
                                input bit inv);
      int v, k, sc, q, rem, mx, mag;
      v  = int'($signed(x));
      k  = fld ? CODE_W + 1 : CODE_W;
      sc = 1 << (IN_W - k);
      q  = (v >= 0) ? v / sc : -((-v + sc - 1) / sc);
      rem = v - q * sc;
      if (rnd && (rem * 2 > sc || (rem * 2 == sc && (q % 2) != 0))) q = q + 1;
      mx = (1 << (k - 1)) - 1;
      if (q > mx) q = mx;
      if (!fld) return q & ((1 << CODE_W) - 1);
      if (q >= 0) return q;
      mag = inv ? -q - 1 : -q;
      if (mag > (1 << CODE_W) - 1) mag = (1 << CODE_W) - 1;
      return (1 << CODE_W) | mag;
   endfunction

   function automatic string tag_for(input logic [IN_W-1:0] x, input bit rnd, input bit fld,
                                     input bit inv);
      if (fld && x[IN_W-1]) return inv ? "R8" : "R7";
      if (fld) return "R6";
      return rnd ? "R3" : "R4";
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [IN_W-1:0] i, input logic [IN_W-1:0] q, input bit rnd,
                        input bit fld, input bit inv);
      i_in = i; q_in = q; round_en = rnd; fold_en = fld; neg_inv = inv;
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit pend;
      int exp_i, exp_q;
      string tag_i, tag_q;
      rst_n = 1'b0;
      drive(12'h7FF, 12'h800, 1'b1, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      // R10: outputs held at zero during reset
      chk("R10", int'({i_sign, i_code}), 0);
      chk("R10", int'({q_sign, q_code}), 0);
      rst_n = 1'b1;

      // Sweep all values and control combinations; R9 via differing rails
      pend = 1'b0;
      exp_i = 0; exp_q = 0;
      for (int ctl = 0; ctl < 8; ctl++) begin
         for (int x = 0; x < (1 << IN_W); x++) begin
            logic [IN_W-1:0] xi, xq;
            @(negedge clk);
            if (pend) begin
               chk(tag_i, int'({i_sign, i_code}), exp_i);
               chk({tag_q, " R9"}, int'({q_sign, q_code}), exp_q);
            end
            xi = IN_W'(x);
            xq = IN_W'(x * 1237 + ctl * 91);
            drive(xi, xq, ctl[0], ctl[1], ctl[2]);
            exp_i = model(xi, ctl[0], ctl[1], ctl[2]);
            exp_q = model(xq, ctl[0], ctl[1], ctl[2]);
            tag_i = tag_for(xi, ctl[0], ctl[1], ctl[2]);
            tag_q = tag_for(xq, ctl[0], ctl[1], ctl[2]);
            pend = 1'b1;
         end
      end
      @(negedge clk);
      chk(tag_i, int'({i_sign, i_code}), exp_i);
      chk(tag_q, int'({q_sign, q_code}), exp_q);

      // R1: width follows fold mode (32 -> 1 folded, 0 plain)
      drive(12'd32, 12'd32, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      chk("R1", int'({i_sign, i_code}), 1);
      drive(12'd32, 12'd32, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R1", int'({i_sign, i_code}), 0);

      // R2: most negative plain code, sign stays 0
      drive(12'h800, 12'h800, 1'b1, 1'b0, 1'b1);
      @(negedge clk);
      chk("R2", int'(i_code), 32);
      chk("R2", int'(q_sign), 0);

      // R7 / R8: -64 input reduces to -2 when folded
      drive(12'hFC0, 12'hFC0, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      chk("R7", int'({i_sign, i_code}), 64 + 2);
      drive(12'hFC0, 12'hFC0, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      chk("R8", int'({i_sign, i_code}), 64 + 1);
      drive(12'h800, 12'h800, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      chk("R7", int'({i_sign, i_code}), 64 + 63);

      // R5: rounding at the positive limit saturates
      drive(12'h7FF, 12'h7FF, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      chk("R5", int'({q_sign, q_code}), 31);
      drive(12'h7FF, 12'h7FF, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      chk("R5", int'({i_sign, i_code}), 63);

      // R9: new input is not visible before the next edge
      drive(12'h100, 12'h100, 1'b0, 1'b0, 1'b0);
      #1;
      chk("R9", int'({i_sign, i_code}), 63);
      @(negedge clk);
      chk("R9", int'({i_sign, i_code}), 4);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule